// File: doc/BRIEF.md
# Extended Interrupt Source and Priority Controller

This block sits beside a CPU core and extends a five-source interrupt scheme with six more requests, for eleven in all. Four of the new requests come from a serial communication channel and two from DMA channels. Each serial-channel request is built from a set of status flags that changes with the servicing mode: while the CPU moves the channel's data, FIFO-level flags raise the requests; while a DMA engine moves it, completion flags do instead, and the transmit-error request also takes in underrun.

An enable register and a priority register, both eight bits with six implemented bits, are reached through a small write/read port. The five original sources come in with their enable and priority bits already decoded. The block holds two priority levels, picks the winning request by level and then by ascending vector address, and shows the CPU a request line and a vector. The CPU answers with an acknowledge when it takes the request and with a return when its routine ends. The block tracks which levels are in service, so a high-level request can nest inside a low-level routine.

Top module: `irq_ext_ctrl`

## Requirements
- R1: After synchronous reset both registers read 0, no level is in service and `irq_req` is 0.
- R2: Register select 0 is the enable register and select 1 the priority register. Bits 5:0 take the written value. Bits 7:6 always read 0 and writes to them are ignored. New-source bit positions are: receive-valid 0, receive-error 1, DMA0 2, transmit-valid 3, DMA1 4, transmit-error 5.
- R3: Receive-valid (vector 2Bh) is `rx_fifo_ne` when `svc_dma`=0 and `rx_done` when `svc_dma`=1.
- R4: Receive-error (vector 33h) is the OR of `crc_err`, `ovr_err`, `rx_abort` and `align_err` in both modes.
- R5: Transmit-valid (vector 43h) is `tx_fifo_nf` when `svc_dma`=0 and `tx_done` when `svc_dma`=1.
- R6: Transmit-error (vector 4Bh) is `no_ack` OR `tx_coll` when `svc_dma`=0, and also ORs in `tx_under` when `svc_dma`=1.
- R7: A DMA request is `dma_done[n]` AND its enable bit; DMA0 uses vector 3Bh, DMA1 vector 53h.
- R8: When `glb_en` is 0 no request is presented.
- R9: An enabled high-priority request wins over any low-priority one.
- R10: Within one level the lowest vector wins. Base sources 0..4 use vectors 03h, 0Bh, 13h, 1Bh, 23h, so transmit-error (4Bh) wins over DMA1 (53h).
- R11: `irq_ack` while `irq_req` is 1 marks the presented level in service. While a low-level routine runs, only high-level requests are presented. While a high-level routine runs, none are.
- R12: `irq_ret` ends the innermost routine: the high level if it is in service, else the low level. When `irq_ret` and a taken `irq_ack` fall in the same cycle, the return is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 enable register, 1 priority register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of selected register |
| glb_en | input | 1 | Global enable for all requests |
| base_req | input | 5 | Requests of the original five sources |
| base_en | input | 5 | Enables of the original sources |
| base_pri | input | 5 | Priority bits of the original sources |
| svc_dma | input | 1 | 1 when DMA services the serial channel |
| rx_fifo_ne | input | 1 | Receive FIFO not empty |
| rx_done | input | 1 | Receive block done |
| crc_err | input | 1 | CRC error |
| ovr_err | input | 1 | Receive overrun |
| rx_abort | input | 1 | Receive abort |
| align_err | input | 1 | Alignment error |
| tx_fifo_nf | input | 1 | Transmit FIFO not full |
| tx_done | input | 1 | Transmit block done |
| no_ack | input | 1 | No acknowledge received |
| tx_coll | input | 1 | Transmit collision detected |
| tx_under | input | 1 | Transmit underrun |
| dma_done | input | 2 | Done flags of DMA channels 0 and 1 |
| irq_req | output | 1 | Request presented to the CPU |
| irq_vec | output | 8 | Vector address of the presented request |
| irq_ack | input | 1 | CPU takes the presented request |
| irq_ret | input | 1 | CPU ends the current routine |

## Verification
The acknowledge of a new request and the return from a running routine can fall in the same clock. The bench provokes this with a low-level routine in service and a high-level request presented, driving both strobes together. It also does this from idle with a low-level request, where the return finds nothing to end. In each case the following cycles show which levels the block now holds: while the high level is held nothing is presented, and after one more return the low-level requests come back. A reference model that pops before it pushes judges this every clock.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int NBASE  = 5;
    localparam int NNEW   = 6;
    localparam int NSRC   = NBASE + NNEW;
    localparam int IDXW   = $clog2(NSRC);
    localparam int REGW   = 8;
    localparam int VECW   = 8;
    localparam logic [VECW-1:0] VEC_FIRST = 8'h03;
    localparam logic [VECW-1:0] VEC_STEP  = 8'h08;

    // bit positions of the new sources in the enable/priority registers
    typedef enum logic [2:0] {
        NB_RXV  = 3'd0,
        NB_RXE  = 3'd1,
        NB_DMA0 = 3'd2,
        NB_TXV  = 3'd3,
        NB_DMA1 = 3'd4,
        NB_TXE  = 3'd5
    } new_bit_e;

    typedef struct packed {
        logic rx_fifo_ne;
        logic rx_done;
        logic crc_err;
        logic ovr_err;
        logic rx_abort;
        logic align_err;
        logic tx_fifo_nf;
        logic tx_done;
        logic no_ack;
        logic tx_coll;
        logic tx_under;
    } chan_flags_t;

    typedef struct packed {
        logic            valid;
        logic            hi;
        logic [IDXW-1:0] idx;
    } pick_t;

    // vector order of the new sources: slot -> register bit
    function automatic int reg_bit_of_slot(input int slot);
        case (slot)
            0: return int'(NB_RXV);
            1: return int'(NB_RXE);
            2: return int'(NB_DMA0);
            3: return int'(NB_TXV);
            4: return int'(NB_TXE);
            default: return int'(NB_DMA1);
        endcase
    endfunction

    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        logic [VECW-1:0] wide;
        wide = {{(VECW-IDXW){1'b0}}, idx};
        return VEC_FIRST + VEC_STEP * wide;
    endfunction

endpackage

// File: rtl/irqx_regs.sv
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int W     = REGW,
    parameter int NIMPL = NNEW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [NIMPL-1:0] en_q,
    output logic [NIMPL-1:0] pri_q
);
    localparam int NRSV = W - NIMPL;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pri_q <= '0;
        end else if (wr) begin
            if (sel) pri_q <= wdata[NIMPL-1:0];
            else     en_q  <= wdata[NIMPL-1:0];
        end
    end

    always_comb begin
        rdata = {{NRSV{1'b0}}, (sel ? pri_q : en_q)};
    end

    // R2: a write lands in the selected register on the next cycle
    p_wr_en_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && !sel) |=> (en_q == $past(wdata[NIMPL-1:0])));
    p_wr_pri_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel) |=> (pri_q == $past(wdata[NIMPL-1:0])));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(en_q) && $stable(pri_q)));

endmodule

// File: rtl/irqx_src_map.sv
module irqx_src_map
    import irqx_pkg::*;
(
    input  logic             svc_dma,
    input  chan_flags_t      fl,
    input  logic [1:0]       dma_done,
    output logic [NNEW-1:0]  raw
);
    always_comb begin
        raw = '0;
        // R3
        raw[NB_RXV]  = svc_dma ? fl.rx_done : fl.rx_fifo_ne;
        // R4
        raw[NB_RXE]  = fl.crc_err | fl.ovr_err | fl.rx_abort | fl.align_err;
        // R5
        raw[NB_TXV]  = svc_dma ? fl.tx_done : fl.tx_fifo_nf;
        // R6
        raw[NB_TXE]  = fl.no_ack | fl.tx_coll | (svc_dma & fl.tx_under);
        // R7
        raw[NB_DMA0] = dma_done[0];
        raw[NB_DMA1] = dma_done[1];
    end
endmodule

// File: rtl/irqx_arb.sv
module irqx_arb
    import irqx_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = IDXW
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] hi,
    input  logic         allow_lo,
    input  logic         allow_hi,
    output pick_t        pick
);
    logic [1:0]    any_l;
    logic [IW-1:0] idx_l [2];

    for (genvar L = 0; L < 2; L++) begin : g_lvl
        logic [N-1:0]  mine;
        logic          any_w;
        logic [IW-1:0] idx_w;
        always_comb begin
            mine  = req & ((L == 1) ? hi : ~hi);
            any_w = 1'b0;
            idx_w = '0;
            for (int i = N - 1; i >= 0; i--) begin
                if (mine[i]) begin
                    any_w = 1'b1;
                    idx_w = IW'(i);
                end
            end
        end
        assign any_l[L] = any_w;
        assign idx_l[L] = idx_w;
    end

    always_comb begin
        pick = '0;
        if (allow_hi && any_l[1]) begin
            pick.valid = 1'b1;
            pick.hi    = 1'b1;
            pick.idx   = idx_l[1];
        end else if (allow_lo && any_l[0]) begin
            pick.valid = 1'b1;
            pick.hi    = 1'b0;
            pick.idx   = idx_l[0];
        end
    end
endmodule

// File: rtl/irqx_svc.sv
module irqx_svc (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output logic act_lo,
    output logic act_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act_lo <= 1'b0;
            act_hi <= 1'b0;
        end else begin
            if (ret) begin
                if (act_hi) act_hi <= 1'b0;
                else        act_lo <= 1'b0;
            end
            if (take) begin
                if (take_hi) act_hi <= 1'b1;
                else         act_lo <= 1'b1;
            end
        end
    end

    // R11: a taken request marks its level in service
    p_push_r11: assert property (@(posedge clk) disable iff (rst)
        take |=> ($past(take_hi) ? act_hi : act_lo));
    // R12: a lone return while high runs ends only the high level
    p_pop_r12: assert property (@(posedge clk) disable iff (rst)
        (ret && !take && act_hi) |=> (!act_hi && (act_lo == $past(act_lo))));

endmodule

// File: rtl/irq_ext_ctrl.sv
module irq_ext_ctrl
    import irqx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REGW-1:0]  reg_wdata,
    output logic [REGW-1:0]  reg_rdata,
    input  logic             glb_en,
    input  logic [NBASE-1:0] base_req,
    input  logic [NBASE-1:0] base_en,
    input  logic [NBASE-1:0] base_pri,
    input  logic             svc_dma,
    input  logic             rx_fifo_ne,
    input  logic             rx_done,
    input  logic             crc_err,
    input  logic             ovr_err,
    input  logic             rx_abort,
    input  logic             align_err,
    input  logic             tx_fifo_nf,
    input  logic             tx_done,
    input  logic             no_ack,
    input  logic             tx_coll,
    input  logic             tx_under,
    input  logic [1:0]       dma_done,
    output logic             irq_req,
    output logic [VECW-1:0]  irq_vec,
    input  logic             irq_ack,
    input  logic             irq_ret
);
    chan_flags_t     fl;
    logic [NNEW-1:0] raw, en_q, pri_q;
    logic [NSRC-1:0] req_all, pri_all;
    logic            act_lo, act_hi;
    pick_t           pick;

    assign fl = '{rx_fifo_ne: rx_fifo_ne, rx_done: rx_done, crc_err: crc_err,
                  ovr_err: ovr_err, rx_abort: rx_abort, align_err: align_err,
                  tx_fifo_nf: tx_fifo_nf, tx_done: tx_done, no_ack: no_ack,
                  tx_coll: tx_coll, tx_under: tx_under};

    irqx_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .rdata(reg_rdata), .en_q(en_q), .pri_q(pri_q)
    );

    irqx_src_map u_map (.svc_dma(svc_dma), .fl(fl), .dma_done(dma_done), .raw(raw));

    // slots in vector order: base sources first, then the new ones
    for (genvar s = 0; s < NSRC; s++) begin : g_slot
        if (s < NBASE) begin : g_base
            assign req_all[s] = glb_en & base_req[s] & base_en[s];
            assign pri_all[s] = base_pri[s];
        end else begin : g_new
            localparam int RB = reg_bit_of_slot(s - NBASE);
            assign req_all[s] = glb_en & raw[RB] & en_q[RB];
            assign pri_all[s] = pri_q[RB];
        end
    end

    irqx_arb u_arb (
        .req(req_all), .hi(pri_all),
        .allow_lo(!act_lo && !act_hi), .allow_hi(!act_hi),
        .pick(pick)
    );

    irqx_svc u_svc (
        .clk(clk), .rst(rst), .take(irq_ack && pick.valid), .take_hi(pick.hi),
        .ret(irq_ret), .act_lo(act_lo), .act_hi(act_hi)
    );

    assign irq_req = pick.valid;
    assign irq_vec = pick.valid ? vec_of(pick.idx) : '0;

    p_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !irq_req);
    p_hi_first_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !pick.hi) |-> ((req_all & pri_all) == '0));
    p_vec_grid_r10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'b011));
    p_hi_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        act_hi |-> !irq_req);
    p_lo_nests_r11: assert property (@(posedge clk) disable iff (rst)
        (act_lo && irq_req) |-> pick.hi);
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!act_lo && !act_hi && reg_rdata == '0));

endmodule

// File: tb/sim_irq_ext_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ext_ctrl;
    localparam time TCK = 20ns;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_wr = 0, reg_sel = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic glb_en = 0;
    logic [4:0] base_req = 0, base_en = 0, base_pri = 0;
    logic svc_dma = 0, rx_fifo_ne = 0, rx_done = 0, crc_err = 0, ovr_err = 0;
    logic rx_abort = 0, align_err = 0, tx_fifo_nf = 0, tx_done = 0;
    logic no_ack = 0, tx_coll = 0, tx_under = 0;
    logic [1:0] dma_done = 0;
    logic irq_req, irq_ack = 0, irq_ret = 0;
    logic [7:0] irq_vec;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural model state
    logic [5:0] m_en = 0, m_pri = 0;
    bit m_lo = 0, m_hi = 0;

    always #(TCK/2) clk = ~clk;

    irq_ext_ctrl u0 (.*);

    // expected request of slot k in vector order (vector 3+8k)
    function automatic bit slot_req(int k);
        bit r;
        if (!glb_en) return 0;
        case (k)
            0, 1, 2, 3, 4: r = base_req[k] && base_en[k];
            5:  r = (svc_dma ? rx_done : rx_fifo_ne) && m_en[0];
            6:  r = (crc_err || ovr_err || rx_abort || align_err) && m_en[1];
            7:  r = dma_done[0] && m_en[2];
            8:  r = (svc_dma ? tx_done : tx_fifo_nf) && m_en[3];
            9:  r = (no_ack || tx_coll || (svc_dma && tx_under)) && m_en[5];
            default: r = dma_done[1] && m_en[4];
        endcase
        return r;
    endfunction

    function automatic bit slot_hi(int k);
        case (k)
            0, 1, 2, 3, 4: return base_pri[k];
            5: return m_pri[0];
            6: return m_pri[1];
            7: return m_pri[2];
            8: return m_pri[3];
            9: return m_pri[5];
            default: return m_pri[4];
        endcase
    endfunction

    // returns slot index, or -1; lvl gives its level
    function automatic int model_pick(output bit lvl);
        lvl = 0;
        if (m_hi) return -1;
        for (int k = 0; k < 11; k++)
            if (slot_req(k) && slot_hi(k)) begin lvl = 1; return k; end
        if (m_lo) return -1;
        for (int k = 0; k < 11; k++)
            if (slot_req(k) && !slot_hi(k)) return k;
        return -1;
    endfunction

    always @(posedge clk) begin
        bit lv;
        int p;
        if (rst) begin
            m_en = 0; m_pri = 0; m_lo = 0; m_hi = 0;
        end else begin
            p = model_pick(lv);
            if (irq_ret) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            if (irq_ack && p >= 0) begin
                if (lv) m_hi = 1; else m_lo = 1;
            end
            if (reg_wr) begin
                if (reg_sel) m_pri = reg_wdata[5:0]; else m_en = reg_wdata[5:0];
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        bit lv;
        int p;
        if (!rst && !done) begin
            p = model_pick(lv);
            chk(cur_req, int'(irq_req), (p >= 0) ? 1 : 0);
            if (p >= 0) chk(cur_req, int'(irq_vec), 3 + 8 * p);
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic look(); @(negedge clk); endtask

    task automatic wreg(bit s, logic [7:0] d);
        cyc(); reg_wr = 1; reg_sel = s; reg_wdata = d;
        cyc(); reg_wr = 0;
    endtask

    task automatic expect_vec(string tag, int v);
        look();
        chk(tag, int'(irq_req), 1);
        chk(tag, int'(irq_vec), v);
        cyc();
    endtask

    task automatic expect_none(string tag);
        look();
        chk(tag, int'(irq_req), 0);
        cyc();
    endtask

    task automatic clear_flags();
        rx_fifo_ne = 0; rx_done = 0; crc_err = 0; ovr_err = 0; rx_abort = 0;
        align_err = 0; tx_fifo_nf = 0; tx_done = 0; no_ack = 0; tx_coll = 0;
        tx_under = 0; dma_done = 0; base_req = 0;
    endtask

    initial begin
        #(TCK * 100000);
        failures++;
        $display("FAIL watchdog: got hang expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        look();
        reg_sel = 0; #1 chk("R1", reg_rdata, 0);
        reg_sel = 1; #1 chk("R1", reg_rdata, 0);
        chk("R1", irq_req, 0);
        cyc();

        // R2: register access, reserved bits
        cur_req = "R2";
        wreg(0, 8'hFF); look(); reg_sel = 0; #1 chk("R2", reg_rdata, 8'h3F); cyc();
        wreg(1, 8'hC5); look(); reg_sel = 1; #1 chk("R2", reg_rdata, 8'h05); cyc();
        look(); reg_sel = 0; #1 chk("R2", reg_rdata, 8'h3F); cyc();
        wreg(1, 8'h00);

        glb_en = 1;
        // R3: receive-valid
        cur_req = "R3";
        wreg(0, 8'h01);
        svc_dma = 0; rx_fifo_ne = 1; expect_vec("R3", 8'h2B);
        rx_fifo_ne = 0; rx_done = 1; expect_none("R3");
        svc_dma = 1; expect_vec("R3", 8'h2B);
        rx_done = 0; rx_fifo_ne = 1; expect_none("R3");
        clear_flags();

        // R4: receive-error in both modes
        cur_req = "R4";
        wreg(0, 8'h02);
        for (int m = 0; m < 2; m++) begin
            svc_dma = m[0];
            crc_err = 1; expect_vec("R4", 8'h33); crc_err = 0;
            ovr_err = 1; expect_vec("R4", 8'h33); ovr_err = 0;
            rx_abort = 1; expect_vec("R4", 8'h33); rx_abort = 0;
            align_err = 1; expect_vec("R4", 8'h33); align_err = 0;
            expect_none("R4");
        end

        // R5: transmit-valid
        cur_req = "R5";
        wreg(0, 8'h08);
        svc_dma = 0; tx_fifo_nf = 1; expect_vec("R5", 8'h43);
        tx_fifo_nf = 0; tx_done = 1; expect_none("R5");
        svc_dma = 1; expect_vec("R5", 8'h43);
        tx_done = 0; tx_fifo_nf = 1; expect_none("R5");
        clear_flags();

        // R6: transmit-error
        cur_req = "R6";
        wreg(0, 8'h20);
        svc_dma = 0; no_ack = 1; expect_vec("R6", 8'h4B); no_ack = 0;
        tx_coll = 1; expect_vec("R6", 8'h4B); tx_coll = 0;
        tx_under = 1; expect_none("R6");
        svc_dma = 1; expect_vec("R6", 8'h4B);
        clear_flags(); svc_dma = 0;

        // R7: DMA channels
        cur_req = "R7";
        wreg(0, 8'h00);
        dma_done = 2'b11; expect_none("R7");
        wreg(0, 8'h04); expect_vec("R7", 8'h3B);
        wreg(0, 8'h10); expect_vec("R7", 8'h53);
        dma_done = 2'b01; expect_none("R7");
        clear_flags();

        // R10: natural order inside one level
        cur_req = "R10";
        wreg(0, 8'h3F); base_en = 5'h1F;
        no_ack = 1; dma_done = 2'b10; expect_vec("R10", 8'h4B);
        base_req = 5'b10100; expect_vec("R10", 8'h13);
        base_req = 5'b00001; expect_vec("R10", 8'h03);
        base_req = 5'b10000; expect_vec("R10", 8'h23);

        // R9: high level first
        cur_req = "R9";
        wreg(1, 8'h10); expect_vec("R9", 8'h53);
        base_pri = 5'b10000; expect_vec("R9", 8'h23);

        // R8: global enable
        cur_req = "R8";
        glb_en = 0; expect_none("R8");
        glb_en = 1; expect_vec("R8", 8'h23);

        // R11: nesting
        cur_req = "R11";
        clear_flags(); base_pri = 0; wreg(1, 8'h00);
        base_req = 5'b00010; expect_vec("R11", 8'h0B);
        irq_ack = 1; look(); cyc(); irq_ack = 0;
        base_req = 5'b00011; expect_none("R11");
        wreg(1, 8'h04); dma_done = 2'b01; expect_vec("R11", 8'h3B);
        irq_ack = 1; look(); cyc(); irq_ack = 0;
        expect_none("R11");

        // R12: returns pop innermost, then ack+ret in one cycle
        cur_req = "R12";
        dma_done = 0;
        irq_ret = 1; cyc(); irq_ret = 0;
        expect_none("R12");
        dma_done = 2'b01; expect_vec("R12", 8'h3B);
        irq_ack = 1; irq_ret = 1; look(); cyc(); irq_ack = 0; irq_ret = 0;
        dma_done = 0; expect_none("R12");
        irq_ret = 1; cyc(); irq_ret = 0;
        expect_vec("R12", 8'h03);
        irq_ack = 1; irq_ret = 1; look(); cyc(); irq_ack = 0; irq_ret = 0;
        expect_none("R12");
        irq_ret = 1; cyc(); irq_ret = 0;
        expect_vec("R12", 8'h03);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule